// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous valid/ready request port and an external asynchronous static RAM of 128K words by 8 bits. Each accepted request is one single-beat read or write, which the controller turns into a pin-level cycle on the RAM. It drives the address, an active-low and an active-high chip enable, an active-low output enable, an active-low write enable, and an 8-bit data-out bus with its tri-state enable. It samples the 8-bit data-in bus.

Every access timing is a parameter counted in clock cycles: read wait, write setup, write pulse, write recovery and bus turnaround. Each parameter must be at least 1. The controller meets each timing by holding a state for that many cycles. It changes the address only while the RAM is deselected or write enable is high. It enables its data drivers only while output enable is high, and it inserts a turnaround gap when a write follows a read, so the RAM and the controller never drive the bus together.

Top module: `sram_ctrl`

## Requirements
- R1: After reset the chip is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1, and `rsp_valid` and `wr_ack` are 0.
- R2: A request accepted with `req_write`=0 selects the chip with `mem_oe_n`=0 for RD_WAIT cycles. It captures `mem_dq_in` on the last of those cycles and presents it on `rsp_rdata` with `rsp_valid` high in the cycle that follows, RD_WAIT cycles after the accepting edge.
- R3: `mem_dq_oe` is high only while `mem_oe_n` is high, so the RAM never drives the bus while the controller does.
- R4: While `mem_we_n` is low, `mem_addr` and `mem_dq_out` stay stable. The address only changes while write enable is high.
- R5: A request accepted with `req_write`=1 runs the following sequence with the chip selected and drivers on: WR_SETUP cycles with `mem_we_n` high, then exactly WR_PULSE cycles with `mem_we_n` low, then WR_RECOV cycles with `mem_we_n` high and the data still driven. The word is then stored at the address.
- R6: When a write follows a read, TURN cycles with the chip deselected and the drivers off come before the write setup. A write that follows a write, or the first access after reset, has no such gap.
- R7: `req_ready` is high exactly when no access is in progress. While it is high the chip is deselected, both strobes are high and the drivers are off. While it is low, `req_valid` is not taken.
- R8: `rsp_valid` and `wr_ack` are single-cycle pulses. `wr_ack` rises in the cycle after write recovery ends, (TURN if any)+WR_SETUP+WR_PULSE+WR_RECOV cycles after the accepting edge.
- R9: The two chip enables always move together: `mem_ce_n` equals the inverse of `mem_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| wr_ack | output | 1 | Write completion pulse |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | RAM active-low chip enable |
| mem_ce | output | 1 | RAM active-high chip enable |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data sampled from the RAM pins |

## Verification
A read response is due RD_WAIT cycles after the accepting edge. A write acknowledge is due WR_SETUP+WR_PULSE+WR_RECOV cycles after that edge, plus TURN when the previous access was a read. The driver records the cycle in which each request is taken and pushes the due cycle with the expected data. The monitor samples at the falling edge and compares the cycle count, the kind of response and the data on each pulse. A bench model of the RAM updates at the falling edge, so the data it presents is stable before the controller's capture edge. The same monitor measures the write-pulse width, address stability, the oe-high gap before the drivers turn on, and the idle pin levels.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
package sram_ctrl_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_SETUP = 3'd3,
        ST_PULSE = 3'd4,
        ST_RECOV = 3'd5
    } ctrl_state_t;

    // Largest of the five timing parameters, used to size the cycle counter.
    function automatic int max_of5(input int a, input int b, input int c,
                                   input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Phase timer: counts cycles spent in the current state.
// Assumes: restart is pulsed on the edge that enters a new state; limit >= 1.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    // Count cycles since the last state entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (restart) count_q <= '0;
        else              count_q <= count_q + 1'b1;
    end

    // The last cycle of the phase is the one where count reaches limit-1.
    assign expired = (count_q == limit - 1'b1);
endmodule

// File: rtl/sram_ctrl_fsm.sv
// Access sequencer: walks read or write phases, each held for its parameter count.
// Assumes: every timing parameter is at least 1 and fits in CNT_W bits.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int RD_WAIT  = 7,
    parameter int WR_SETUP = 1,
    parameter int WR_PULSE = 5,
    parameter int WR_RECOV = 1,
    parameter int TURN     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    output logic        req_ready,
    output logic        accept,
    output logic        rd_capture,
    output logic        wr_finish,
    output ctrl_state_t state_next
);
    ctrl_state_t      state_q;
    logic             after_read_q;
    logic             expired;
    logic             restart;
    logic [CNT_W-1:0] limit;

    // Hold time of the current state.
    always_comb begin
        case (state_q)
            ST_READ:  limit = CNT_W'(RD_WAIT);
            ST_TURN:  limit = CNT_W'(TURN);
            ST_SETUP: limit = CNT_W'(WR_SETUP);
            ST_PULSE: limit = CNT_W'(WR_PULSE);
            ST_RECOV: limit = CNT_W'(WR_RECOV);
            default:  limit = CNT_W'(1);
        endcase
    end

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign rd_capture = (state_q == ST_READ)  && expired;
    assign wr_finish  = (state_q == ST_RECOV) && expired;
    assign restart    = (state_next != state_q);

    // Next-state selection.
    always_comb begin
        state_next = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)       state_next = ST_READ;
                    else if (after_read_q) state_next = ST_TURN;
                    else                  state_next = ST_SETUP;
                end
            end
            ST_READ:  if (expired) state_next = ST_IDLE;
            ST_TURN:  if (expired) state_next = ST_SETUP;
            ST_SETUP: if (expired) state_next = ST_PULSE;
            ST_PULSE: if (expired) state_next = ST_RECOV;
            ST_RECOV: if (expired) state_next = ST_IDLE;
            default:  state_next = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_next;
    end

    // Remember whether the last access was a read, to decide on turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n)                  after_read_q <= 1'b0;
        else if (rd_capture)         after_read_q <= 1'b1;
        else if (accept && req_write) after_read_q <= 1'b0;
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
// Pin and data registers: latches the request, decodes registered RAM strobes
// from the next state, captures read data and raises the response pulses.
// Assumes: state_next comes from the sequencer in the same cycle.
module sram_ctrl_datapath
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic              wr_finish,
    input  ctrl_state_t       state_next,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    logic sel_d, oe_d, we_d, drv_d;

    // Strobe levels implied by the state about to be entered.
    always_comb begin
        sel_d = (state_next == ST_READ)  || (state_next == ST_SETUP) ||
                (state_next == ST_PULSE) || (state_next == ST_RECOV);
        oe_d  = (state_next == ST_READ);
        we_d  = (state_next == ST_PULSE);
        drv_d = (state_next == ST_SETUP) || (state_next == ST_PULSE) ||
                (state_next == ST_RECOV);
    end

    // Registered RAM control pins, glitch-free at the board.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= ~sel_d;
            mem_ce    <= sel_d;
            mem_oe_n  <= ~oe_d;
            mem_we_n  <= ~we_d;
            mem_dq_oe <= drv_d;
        end
    end

    // Address and write data, loaded only when a request is taken in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Read capture and single-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
            wr_ack    <= 1'b0;
        end else begin
            if (rd_capture) rsp_rdata <= mem_dq_in;
            rsp_valid <= rd_capture;
            wr_ack    <= wr_finish;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
// Asynchronous SRAM controller top: valid/ready host port to RAM pin cycles.
// Assumes: timing parameters (cycles) are all >= 1; one access at a time.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int RD_WAIT  = 7,
    parameter int WR_SETUP = 1,
    parameter int WR_PULSE = 5,
    parameter int WR_RECOV = 1,
    parameter int TURN     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_T = max_of5(RD_WAIT, WR_SETUP, WR_PULSE, WR_RECOV, TURN);
    localparam int CNT_W = $clog2(MAX_T + 1) + 1;

    logic        accept, rd_capture, wr_finish;
    ctrl_state_t state_next;

    sram_ctrl_fsm #(
        .CNT_W(CNT_W), .RD_WAIT(RD_WAIT), .WR_SETUP(WR_SETUP),
        .WR_PULSE(WR_PULSE), .WR_RECOV(WR_RECOV), .TURN(TURN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_finish  (wr_finish),
        .state_next (state_next)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_capture (rd_capture),
        .wr_finish  (wr_finish),
        .state_next (state_next),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .wr_ack     (wr_ack),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the SRAM controller pins; bound to every sram_ctrl.
// Assumes: synchronous active-low reset shared with the controller.
module sram_ctrl_chk #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int WR_PULSE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic [15:0] we_run;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 1'b1;
        else                we_run <= '0;
    end

    a_r3_drive_only_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r4_addr_stable_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    a_r5_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe && mem_oe_n));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && we_run != 0) |-> (we_run == 16'(WR_PULSE)));

    a_r7_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);

    a_r9_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n == !mem_ce);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_PULSE(WR_PULSE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .wr_ack     (wr_ack),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
// Scoreboard bench for sram_ctrl with a behavioural RAM model on the pins.
module sim_sram_ctrl;
    localparam int AW  = 17;
    localparam int DW  = 8;
    localparam int RDW = 4;
    localparam int SET = 2;
    localparam int PUL = 5;
    localparam int REC = 2;
    localparam int TRN = 3;
    localparam logic [DW-1:0] BLANK = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          wr_ack;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit            is_wr;
        logic [DW-1:0] data;
        int            due;
    } exp_t;
    exp_t exp_q[$];

    logic [DW-1:0] ram[int];
    logic [DW-1:0] ref_mem[int];
    bit last_rd = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_SETUP(SET),
        .WR_PULSE(PUL), .WR_RECOV(REC), .TURN(TRN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_ack(wr_ack),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: waits for ready, issues one request and records its expectation.
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        e.is_wr = wr;
        if (wr) begin
            e.data  = d;
            e.due   = cyc + 1 + (last_rd ? TRN : 0) + SET + PUL + REC;
            ref_mem[int'(a)] = d;
            last_rd = 1'b0;
        end else begin
            e.data  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : BLANK;
            e.due   = cyc + 1 + RDW;
            last_rd = 1'b1;
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        // R7: one cycle after acceptance the controller must be busy.
        check(req_ready == 1'b0, "R7 busy ready", req_ready, 0);
    endtask

    // RAM model plus pin monitor, all on the falling edge.
    int  we_run = 0;
    int  oe_gap = 1000;
    bit  prev_we_low = 1'b0;
    bit  prev_drv = 1'b0;
    bit  prev_rsp = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            sel = !mem_ce_n && mem_ce;
            // R9 paired enables
            if (mem_ce_n != !mem_ce) check(0, "R9 enables", mem_ce_n, !mem_ce);
            // R3 no contention
            if (sel && !mem_oe_n && mem_dq_oe) check(0, "R3 contention", mem_dq_oe, 0);
            // R7 idle pin levels
            if (req_ready && !(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe))
                check(0, "R7 idle pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
            // R4 address and data stable through the write pulse
            if (!mem_we_n && prev_we_low)
                check(mem_addr == prev_addr, "R4 addr stable", mem_addr, prev_addr);
            // R5 pulse width and write into the model
            if (!mem_we_n) begin
                we_run++;
                if (sel && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
                else check(0, "R5 select/drive during pulse", {sel, mem_dq_oe}, 2'b11);
            end else if (we_run != 0) begin
                check(we_run == PUL, "R5 pulse width", we_run, PUL);
                we_run = 0;
            end
            // R6 turnaround gap before drivers turn on
            if (mem_dq_oe && !prev_drv)
                check(oe_gap >= TRN + 1, "R6 turnaround gap", oe_gap, TRN + 1);
            if (!mem_oe_n) oe_gap = 0; else oe_gap++;
            // R8 single-cycle response pulse
            if (rsp_valid && prev_rsp) check(0, "R8 rsp pulse", 1, 0);
            // Scoreboard: R2 read data/latency, R8 write ack latency
            if (rsp_valid || wr_ack) begin
                if (exp_q.size() == 0) check(0, "R2 unexpected response", 1, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_wr) begin
                        check(wr_ack && !rsp_valid, "R8 write ack kind", wr_ack, 1);
                        check(cyc == e.due, "R8 write ack cycle", cyc, e.due);
                    end else begin
                        check(rsp_valid && !wr_ack, "R2 read rsp kind", rsp_valid, 1);
                        check(cyc == e.due, "R2 read latency", cyc, e.due);
                        check(rsp_rdata == e.data, "R2 read data", rsp_rdata, e.data);
                    end
                end
            end
            // RAM drives the bus only when selected for a read
            if (sel && !mem_oe_n && mem_we_n)
                mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : BLANK;
            else
                mem_dq_in = 8'h00;
            prev_we_low = !mem_we_n;
            prev_addr   = mem_addr;
            prev_drv    = mem_dq_oe;
            prev_rsp    = rsp_valid;
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired with %0d items pending", exp_q.size());
        finish_run();
    end

    // Stimulus.
    initial begin
        logic [AW-1:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state observed while reset is held and right after release
        check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1 reset pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !wr_ack, "R1 reset handshake",
              {req_ready, rsp_valid, wr_ack}, 3'b100);

        // R5 first write after reset: no turnaround (R6)
        issue(1'b1, 17'h1ABCD, 8'h3C);
        issue(1'b0, 17'h1ABCD, 8'h00);          // R2 read back
        issue(1'b1, 17'h00000, 8'hFF);          // R6 write after read
        issue(1'b1, 17'h1FFFF, 8'h00);          // R6 write after write, no gap
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h1FFFF, 8'h00);          // back-to-back reads
        issue(1'b0, 17'h12345, 8'h00);          // unwritten location
        repeat (5) @(negedge clk);              // idle gap, R7 pins checked
        issue(1'b1, 17'h12345, 8'hA7);          // write after read with idle gap
        issue(1'b0, 17'h12345, 8'h00);

        // Mixed pattern from a shift register.
        lfsr = 17'h0ACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[15:0], lfsr[16] ^ lfsr[13]};
            issue(lfsr[0], {lfsr[3:0], 13'h0} | 17'(i % 7), lfsr[15:8] ^ 8'(i));
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(req_ready && mem_ce_n && !mem_dq_oe, "R7 final idle",
              {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
        finish_run();
    end
endmodule